// File: doc/BRIEF.md
# Pseudo-Random Operand Self-Test Harness

This block runs a built-in self-test on a small two-operand arithmetic/logic unit. Two 8-bit linear feedback shift registers produce the operands. A 10-bit up-counter paces the test, and its two top bits select which of four operations the unit performs. The two 8-bit results are compressed, cycle by cycle, into two 8-bit multiple-input signature registers. When the test ends, one pair of signatures stands for the whole response, and it can be compared against a known-good pair.

The test is paced by a one-cycle step strobe or by a continuous run level. Each generator can be given a new seed with its own load strobe while the block is paused or between runs. At each change of operation, both generators go back to their most recently loaded seed, so every operation sees the same operand stream. The count stops at all ones, and the signatures freeze there.

Top module: `lfsr_misr_harness`

## Requirements
- R1: While synchronous active-high reset is high at a clock edge, the count and both signatures become 0x00 and 0x000. Both operands, and both stored seeds, become 0x01.
- R2: A high load_a (load_b) at a clock edge writes seed_a (seed_b) into operand A (B) and into that generator's stored seed. A load wins over an advance on the same edge. Each load affects only its own generator.
- R3: The block advances on a clock edge only when (step OR run) is high and done is low. Otherwise the count, both signatures and any operand that is not being loaded keep their values.
- R4: Each advance adds one to the 10-bit count. done is high exactly when the count is 0x3FF.
- R5: On an advance, an operand that is not reloaded takes (value << 1) XOR (0x71 if bit 7 was set, else 0x00). This is the polynomial x^8+x^6+x^5+x^4+1.
- R6: On an advance taken while the low 8 bits of the count are 0xFF, both operands take their stored seeds instead of shifting. The operand stream therefore restarts whenever count[9:8] changes.
- R7: count[9:8] selects the operation giving results X and Y. 0 gives X=A+B, Y=A-B. 1 gives X=A&B, Y=A|B. 2 gives X=A^B, Y=~A. 3 gives X=A, Y=B. All results are 8 bits, modulo 256.
- R8: On each advance, each signature takes (sig << 1) XOR (0x1D if bit 7 was set, else 0x00) XOR its result, using the results from before the edge. This is the polynomial x^8+x^4+x^3+x^2+1.
- R9: sign_x and sign_y equal bit 7 of the current X and Y.
- R10: Once done is high, step and run change neither the count nor the signatures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_a | input | 1 | Load seed_a into generator A |
| load_b | input | 1 | Load seed_b into generator B |
| seed_a | input | 8 | Seed for generator A |
| seed_b | input | 8 | Seed for generator B |
| step | input | 1 | Single-advance strobe |
| run | input | 1 | Continuous advance level |
| a_op | output | 8 | Current operand A |
| b_op | output | 8 | Current operand B |
| sig_x | output | 8 | Signature of result X |
| sig_y | output | 8 | Signature of result Y |
| sign_x | output | 1 | Bit 7 of result X |
| sign_y | output | 1 | Bit 7 of result Y |
| count | output | 10 | Test counter |
| done | output | 1 | Count has reached 0x3FF |

## Verification
The assertions check on every cycle that the count moves by exactly one on each advance and holds otherwise, and that it never leaves 0x3FF. They also check that the operands and signatures do not move without an advance or a load, that a load wins on the same edge, and that the seed comes back at each operation boundary. Whether the signatures are correct over all four operations, and which seed-dependent patterns the generators produce, can only be shown by the bench's full-length runs, which compare against its own model. The same holds for freezing after done under continued stepping.

// File: rtl/lfsr_misr_harness.sv
module lfsr_misr_harness #(
  parameter int W = 8,
  parameter int CW = 10,
  parameter logic [W-1:0] LFSR_TAPS = 8'h71,
  parameter logic [W-1:0] MISR_TAPS = 8'h1D,
  parameter logic [W-1:0] RST_SEED = 8'h01
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_a,
  input  logic          load_b,
  input  logic [W-1:0]  seed_a,
  input  logic [W-1:0]  seed_b,
  input  logic          step,
  input  logic          run,
  output logic [W-1:0]  a_op,
  output logic [W-1:0]  b_op,
  output logic [W-1:0]  sig_x,
  output logic [W-1:0]  sig_y,
  output logic          sign_x,
  output logic          sign_y,
  output logic [CW-1:0] count,
  output logic          done
);

  localparam logic [CW-1:0] LAST = '1;

  logic [W-1:0] keep_a, keep_b, res_x, res_y;
  logic         adv, wrap;

  function automatic logic [W-1:0] lfsr_nx(input logic [W-1:0] v);
    return (v << 1) ^ (v[W-1] ? LFSR_TAPS : '0);
  endfunction

  function automatic logic [W-1:0] misr_nx(input logic [W-1:0] s, input logic [W-1:0] d);
    return (s << 1) ^ (s[W-1] ? MISR_TAPS : '0) ^ d;
  endfunction

  assign done = (count == LAST);
  assign adv  = (step | run) & ~done;
  assign wrap = &count[W-1:0];

  always_comb begin
    unique case (count[CW-1:CW-2])
      2'd0: begin res_x = a_op + b_op; res_y = a_op - b_op; end
      2'd1: begin res_x = a_op & b_op; res_y = a_op | b_op; end
      2'd2: begin res_x = a_op ^ b_op; res_y = ~a_op;       end
      default: begin res_x = a_op;     res_y = b_op;        end
    endcase
  end

  assign sign_x = res_x[W-1];
  assign sign_y = res_y[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      sig_x  <= '0;
      sig_y  <= '0;
      a_op   <= RST_SEED;
      b_op   <= RST_SEED;
      keep_a <= RST_SEED;
      keep_b <= RST_SEED;
    end else begin
      if (adv) begin
        count <= count + 1'b1;
        sig_x <= misr_nx(sig_x, res_x);
        sig_y <= misr_nx(sig_y, res_y);
      end
      if (load_a) begin
        a_op   <= seed_a;
        keep_a <= seed_a;
      end else if (adv) begin
        a_op <= wrap ? keep_a : lfsr_nx(a_op);
      end
      if (load_b) begin
        b_op   <= seed_b;
        keep_b <= seed_b;
      end else if (adv) begin
        b_op <= wrap ? keep_b : lfsr_nx(b_op);
      end
    end
  end

  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    ((step | run) && !done) |=> count == $past(count) + 1'b1);

  assert_count_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (count == LAST) |=> (count == LAST) && $stable(sig_x) && $stable(sig_y));

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !(step | run) |=> $stable(count) && $stable(sig_x) && $stable(sig_y));

  assert_hold_a_R3: assert property (@(posedge clk) disable iff (rst)
    (!load_a && !((step | run) && !done)) |=> $stable(a_op));

  assert_load_wins_R2: assert property (@(posedge clk) disable iff (rst)
    load_b |=> b_op == $past(seed_b));

  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    ((step | run) && !done && count[W-1:0] == '1 && !load_a) |=> a_op == keep_a);

endmodule

// File: tb/test_lfsr_misr_harness.sv
`timescale 1ns/1ps
module test_lfsr_misr_harness;
  logic clk = 0, rst = 1, load_a = 0, load_b = 0, step = 0, run = 0;
  logic [7:0] seed_a = 0, seed_b = 0;
  logic [7:0] a_op, b_op, sig_x, sig_y;
  logic sign_x, sign_y, done;
  logic [9:0] count;
  int total = 0, bad = 0;
  bit finished = 0;

  logic [7:0] ma, mb, ka, kb, mx, my;
  int mk;

  lfsr_misr_harness i_lfsr_misr_harness (.clk, .rst, .load_a, .load_b, .seed_a, .seed_b,
    .step, .run, .a_op, .b_op, .sig_x, .sig_y, .sign_x, .sign_y, .count, .done);

  always #2.5 clk = ~clk;

  function automatic logic [7:0] gen_nx(input logic [7:0] v);
    return {v[6:0], 1'b0} ^ (v[7] ? 8'h71 : 8'h00);
  endfunction
  function automatic logic [7:0] sig_nx(input logic [7:0] s, input logic [7:0] d);
    return {s[6:0], 1'b0} ^ (s[7] ? 8'h1D : 8'h00) ^ d;
  endfunction
  function automatic logic [15:0] uut(input int sel, input logic [7:0] a, input logic [7:0] b);
    case (sel)
      0: return {8'(a + b), 8'(a - b)};
      1: return {a & b, a | b};
      2: return {a ^ b, ~a};
      default: return {a, b};
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_rst();
    ma = 8'h01; mb = 8'h01; ka = 8'h01; kb = 8'h01; mx = 0; my = 0; mk = 0;
  endtask

  // one clock edge with the currently driven inputs, model updated alongside
  task automatic tick();
    logic [15:0] r;
    bit a;
    a = (step | run) && (mk != 1023);
    r = uut(mk >> 8, ma, mb);
    if (rst) model_rst();
    else begin
      if (load_a) begin ma = seed_a; ka = seed_a; end
      else if (a) ma = ((mk & 255) == 255) ? ka : gen_nx(ma);
      if (load_b) begin mb = seed_b; kb = seed_b; end
      else if (a) mb = ((mk & 255) == 255) ? kb : gen_nx(mb);
      if (a) begin mx = sig_nx(mx, r[15:8]); my = sig_nx(my, r[7:0]); mk++; end
    end
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst = 1; tick(); tick(); rst = 0;
    chk("R1 count", count, 0); chk("R1 sig_x", sig_x, 0); chk("R1 sig_y", sig_y, 0);
    chk("R1 a_op", a_op, 1); chk("R1 b_op", b_op, 1); chk("R4 done low", done, 0);
  endtask

  task automatic t_load();
    seed_a = 8'h5A; load_a = 1; tick(); load_a = 0;
    chk("R2 a loaded", a_op, 8'h5A); chk("R2 b untouched", b_op, 8'h01);
    seed_b = 8'hC3; load_b = 1; step = 1; tick(); load_b = 0; step = 0;
    chk("R2 load over advance", b_op, 8'hC3); chk("R5 a shifted", a_op, 8'hB4);
    chk("R4 count one", count, 1);
  endtask

  task automatic t_hold();
    logic [7:0] sx;
    sx = sig_x;
    for (int i = 0; i < 5; i++) tick();
    chk("R3 count held", count, 1); chk("R3 a held", a_op, 8'hB4);
    chk("R3 sig held", sig_x, sx);
  endtask

  task automatic t_full(input logic [7:0] sa, input logic [7:0] sb);
    rst = 1; tick(); rst = 0;
    seed_a = sa; seed_b = sb; load_a = 1; load_b = 1; tick(); load_a = 0; load_b = 0;
    run = 1;
    while (mk != 1023) begin
      logic [15:0] r;
      r = uut(mk >> 8, ma, mb);
      chk("R9 sign_x", sign_x, r[15]); chk("R9 sign_y", sign_y, r[7]);
      tick();
      chk("R5 a_op", a_op, ma); chk("R5 b_op", b_op, mb); chk("R4 count", count, mk);
      if ((mk & 255) == 0) begin
        chk("R6 restart a", a_op, sa); chk("R6 restart b", b_op, sb);
      end
    end
    run = 0;
    chk("R4 done", done, 1);
    chk("R7 R8 sig_x", sig_x, mx); chk("R7 R8 sig_y", sig_y, my);
  endtask

  task automatic t_after_done();
    logic [7:0] sx, sy;
    sx = sig_x; sy = sig_y;
    step = 1; tick(); step = 0; tick(); run = 1;
    for (int i = 0; i < 8; i++) tick();
    run = 0;
    chk("R10 count", count, 10'h3FF); chk("R10 sig_x", sig_x, sx);
    chk("R10 sig_y", sig_y, sy); chk("R10 a_op", a_op, ma);
  endtask

  initial begin
    model_rst();
    @(negedge clk);
    t_reset();
    t_load();
    t_hold();
    t_full(8'h5A, 8'hC3);
    t_after_done();
    t_full(8'hE7, 8'h81);
    t_reset();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule